// File: doc/BRIEF.md
# Youngest-First Chunk Rollback Sequencer

When a core running a redundant master/checker thread pair detects a transient fault, all of its in-flight chunks must be undone before execution can restart from the last verified register checkpoint. This sequencer drives that unwind. It starts with the youngest in-flight chunk and moves toward the oldest. Before undoing a chunk, it looks at the chunk's producer row, which lists the other cores that consumed data from that chunk. If the row is empty, the chunk is handed straight to the log-walking unit for a local undo. If the row is not empty, the sequencer first sends a rollback strobe to every listed core. It then holds that chunk until each of those cores has acknowledged. This ordering makes consumers undo before their producers across the chip.

Other cores can also ask this core to roll back, naming a target chunk. The sequencer keeps one queued request per source core. A request acts as a recovery trigger when its target is still live. It is acknowledged as soon as the target chunk has been undone, or at once if the target is already gone. The master thread is stalled for the whole unwind. Once chunk 0 has been undone, a one-cycle strobe copies the checkpoint into both threads and the stall is released.

The surrounding core keeps `live_cnt_i` stable during a recovery. Chunk ids run from 0 (oldest) to `live_cnt_i-1` (youngest). The write-back of logged old values and the clearing of a chunk's signatures and log pointer belong to the log-walking unit, which answers each undo request with a done pulse.

Top module: `chunk_rollback_seq`

## Requirements
- R1: After reset, `stall_o`, `undo_req_o`, `ckpt_restore_o`, `ack_out_o` are 0 and `rb_out_o` is all zeros.
- R2: A `fault_i` pulse while idle raises `stall_o` on the next cycle. `stall_o` then stays high until the cycle after the checkpoint strobe, when it falls.
- R3: Undo requests name chunks `live_cnt_i-1`, `live_cnt_i-2`, ... down to 0, one chunk per `undo_req_o`/`undo_done_i` handshake.
- R4: A chunk whose producer row is zero is undone without any rollback strobe. Producer rows are packed so that bit `k*NCORE+c` of `prod_map_i` means core c consumed data from chunk k.
- R5: For a chunk with a nonzero producer row, `rb_out_o` equals that row for exactly one cycle. The chunk's undo request is not raised until every core in the row has pulsed its `ack_in_i` bit. Acknowledgements from cores not in the row are ignored.
- R6: An incoming rollback request (`rb_req_i`, source `rb_src_i`, target `rb_chunk_i`) whose target is live starts a recovery if none is running. It is answered with `ack_out_o`=1 and `ack_dst_o`=source, and only after the target chunk's undo handshake has completed.
- R7: A request whose target has already been undone, or is not in flight (target >= `live_cnt_i` while idle), is acknowledged without any undo and without raising `stall_o`.
- R8: Once chunk 0 has been undone, `ckpt_restore_o` is high for exactly one cycle. `stall_o` falls on the following cycle.
- R9: A request that arrives during a recovery is queued and acknowledged later, never dropped.
- R10: A fault with `live_cnt_i`=0 produces the checkpoint strobe with no undo request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fault_i | input | 1 | Local fault detected (pulse) |
| live_cnt_i | input | CW+1 | Number of in-flight chunks |
| prod_map_i | input | NCHUNK*NCORE | Producer rows, bit k*NCORE+c = core c consumed from chunk k |
| rb_req_i | input | 1 | Incoming rollback request valid |
| rb_src_i | input | NW | Requesting core |
| rb_chunk_i | input | CW | Chunk the requester needs undone |
| ack_in_i | input | NCORE | Acknowledgements from consumer cores |
| undo_done_i | input | 1 | Log-walking unit finished the current undo |
| rb_out_o | output | NCORE | Rollback strobes to consumer cores |
| ack_out_o | output | 1 | Acknowledge to a requester |
| ack_dst_o | output | NW | Core receiving the acknowledge |
| undo_req_o | output | 1 | Local undo request to the log-walking unit |
| undo_chunk_o | output | CW | Chunk to undo |
| ckpt_restore_o | output | 1 | Write checkpoint into master and slave |
| stall_o | output | 1 | Master held during recovery |

## Verification
The hardest case to reach from the ports is a rollback request that arrives while the sequencer is parked on a chunk, waiting for consumer acknowledgements, and whose target has already been undone. The bench gets there by watching for the rollback strobe of chunk 0, which has a nonzero row. It then issues a request for chunk 3 while its consumer model is still holding back the real acknowledgements and injecting stray ones from unlisted cores. The scoreboard expects that acknowledge between the strobe and the final undo. A separate run queues a request for the oldest chunk in the middle of an externally triggered unwind, so that its acknowledge has to land after the checkpoint strobe.

// File: rtl/rcv_pkg.sv
// Shared types for the chunk rollback sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package rcv_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SCAN    = 3'd1,
        ST_WAIT    = 3'd2,
        ST_UNDO    = 3'd3,
        ST_RESTORE = 3'd4
    } walk_st_t;
endpackage

// File: rtl/rcv_req_table.sv
// Incoming rollback request table. Holds one pending request per source
// core and acknowledges the lowest-numbered source whose target chunk is
// at or above the undone floor.
// Assumes: a source does not re-request before it is acknowledged.
module rcv_req_table #(
    parameter int NCHUNK = 4,
    parameter int NCORE  = 4,
    parameter int CW     = $clog2(NCHUNK),
    parameter int NW     = $clog2(NCORE)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_v_i,
    input  logic [NW-1:0] req_src_i,
    input  logic [CW-1:0] req_chunk_i,
    input  logic [CW:0]   floor_i,
    output logic          unsat_o,
    output logic          ack_v_o,
    output logic [NW-1:0] ack_dst_o
);
    logic [NCORE-1:0] pend_q;
    logic [CW-1:0]    tgt_q [NCORE];
    logic [NCORE-1:0] sat;
    logic             any_sat;
    logic [NW-1:0]    sel;

    // Mark entries whose target is already undone and pick the lowest.
    always_comb begin
        any_sat = 1'b0;
        sel     = '0;
        for (int c = NCORE - 1; c >= 0; c--) begin
            sat[c] = pend_q[c] && ({1'b0, tgt_q[c]} >= floor_i);
            if (sat[c]) begin
                any_sat = 1'b1;
                sel     = NW'(c);
            end
        end
        unsat_o = |(pend_q & ~sat);
    end

    // Store new requests, retire the acknowledged one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q    <= '0;
            ack_v_o   <= 1'b0;
            ack_dst_o <= '0;
            for (int c = 0; c < NCORE; c++) tgt_q[c] <= '0;
        end else begin
            ack_v_o   <= any_sat;
            ack_dst_o <= sel;
            if (any_sat) pend_q[sel] <= 1'b0;
            if (req_v_i) begin
                pend_q[req_src_i] <= 1'b1;
                tgt_q[req_src_i]  <= req_chunk_i;
            end
        end
    end
endmodule

// File: rtl/rcv_ack_mask.sv
// Outstanding consumer acknowledgement mask for the chunk being unwound.
// Assumes: load and acknowledgements in one cycle resolve in favour of load.
module rcv_ack_mask #(
    parameter int NCORE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [NCORE-1:0] load_val_i,
    input  logic [NCORE-1:0] ack_i,
    output logic [NCORE-1:0] mask_o,
    output logic             clear_o
);
    // Arm with the producer row, then drop bits as consumers acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)      mask_o <= '0;
        else if (load_i) mask_o <= load_val_i;
        else             mask_o <= mask_o & ~ack_i;
    end

    // Nothing left to wait for.
    assign clear_o = (mask_o == '0);
endmodule

// File: rtl/rcv_walker.sv
// Recovery walk state machine: youngest to oldest chunk, optional consumer
// rollback round per chunk, local undo handshake, checkpoint restore.
// Assumes: live_cnt_i stays stable while stall_o is high.
module rcv_walker
    import rcv_pkg::*;
#(
    parameter int NCHUNK = 4,
    parameter int NCORE  = 4,
    parameter int CW     = $clog2(NCHUNK)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [CW:0]             live_cnt_i,
    input  logic [NCHUNK*NCORE-1:0] prod_map_i,
    input  logic                    mask_clear_i,
    input  logic                    undo_done_i,
    output logic                    load_o,
    output logic [NCORE-1:0]        rb_out_o,
    output logic                    undo_req_o,
    output logic [CW-1:0]           undo_chunk_o,
    output logic                    ckpt_o,
    output logic                    stall_o,
    output logic [CW:0]             floor_o
);
    walk_st_t         st_q, st_d;
    logic [CW-1:0]    cur_q, cur_d;
    logic [CW:0]      floor_q, floor_d;
    logic [NCORE-1:0] row;

    // Producer row of the chunk under the cursor.
    assign row = prod_map_i[int'(cur_q) * NCORE +: NCORE];

    // Next-state and per-state strobes.
    always_comb begin
        st_d       = st_q;
        cur_d      = cur_q;
        floor_d    = floor_q;
        load_o     = 1'b0;
        rb_out_o   = '0;
        undo_req_o = 1'b0;
        ckpt_o     = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (start_i) begin
                    if (live_cnt_i == '0) begin
                        floor_d = '0;
                        st_d    = ST_RESTORE;
                    end else begin
                        cur_d   = CW'(live_cnt_i - 1'b1);
                        floor_d = live_cnt_i;
                        st_d    = ST_SCAN;
                    end
                end
            end
            ST_SCAN: begin
                if (row != '0) begin
                    load_o   = 1'b1;
                    rb_out_o = row;
                    st_d     = ST_WAIT;
                end else begin
                    st_d = ST_UNDO;
                end
            end
            ST_WAIT: begin
                if (mask_clear_i) st_d = ST_UNDO;
            end
            ST_UNDO: begin
                undo_req_o = 1'b1;
                if (undo_done_i) begin
                    floor_d = {1'b0, cur_q};
                    if (cur_q == '0) begin
                        st_d = ST_RESTORE;
                    end else begin
                        cur_d = cur_q - 1'b1;
                        st_d  = ST_SCAN;
                    end
                end
            end
            ST_RESTORE: begin
                ckpt_o = 1'b1;
                st_d   = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State, cursor and undone-floor registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            cur_q   <= '0;
            floor_q <= '0;
        end else begin
            st_q    <= st_d;
            cur_q   <= cur_d;
            floor_q <= floor_d;
        end
    end

    assign undo_chunk_o = cur_q;
    assign stall_o      = (st_q != ST_IDLE);
    // While idle, everything at or above the live count counts as undone.
    assign floor_o      = stall_o ? floor_q : live_cnt_i;
endmodule

// File: rtl/chunk_rollback_seq.sv
// Top of the fault recovery sequencer. Joins the walk state machine, the
// consumer acknowledgement mask and the incoming request table.
// Assumes: producer rows are stable during recovery; one request per source.
module chunk_rollback_seq #(
    parameter int NCHUNK = 4,
    parameter int NCORE  = 4,
    parameter int CW     = $clog2(NCHUNK),
    parameter int NW     = $clog2(NCORE)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fault_i,
    input  logic [CW:0]             live_cnt_i,
    input  logic [NCHUNK*NCORE-1:0] prod_map_i,
    input  logic                    rb_req_i,
    input  logic [NW-1:0]           rb_src_i,
    input  logic [CW-1:0]           rb_chunk_i,
    input  logic [NCORE-1:0]        ack_in_i,
    input  logic                    undo_done_i,
    output logic [NCORE-1:0]        rb_out_o,
    output logic                    ack_out_o,
    output logic [NW-1:0]           ack_dst_o,
    output logic                    undo_req_o,
    output logic [CW-1:0]           undo_chunk_o,
    output logic                    ckpt_restore_o,
    output logic                    stall_o
);
    logic             unsat;
    logic             start;
    logic             mask_load;
    logic             mask_clear;
    logic [NCORE-1:0] pend_mask;
    logic [CW:0]      floor;

    // A local fault or a request for a still-live chunk starts a walk.
    assign start = fault_i | unsat;

    rcv_walker #(.NCHUNK(NCHUNK), .NCORE(NCORE), .CW(CW)) u_walk (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .live_cnt_i   (live_cnt_i),
        .prod_map_i   (prod_map_i),
        .mask_clear_i (mask_clear),
        .undo_done_i  (undo_done_i),
        .load_o       (mask_load),
        .rb_out_o     (rb_out_o),
        .undo_req_o   (undo_req_o),
        .undo_chunk_o (undo_chunk_o),
        .ckpt_o       (ckpt_restore_o),
        .stall_o      (stall_o),
        .floor_o      (floor)
    );

    rcv_ack_mask #(.NCORE(NCORE)) u_mask (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (mask_load),
        .load_val_i (rb_out_o),
        .ack_i      (ack_in_i),
        .mask_o     (pend_mask),
        .clear_o    (mask_clear)
    );

    rcv_req_table #(.NCHUNK(NCHUNK), .NCORE(NCORE), .CW(CW), .NW(NW)) u_tab (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_v_i     (rb_req_i),
        .req_src_i   (rb_src_i),
        .req_chunk_i (rb_chunk_i),
        .floor_i     (floor),
        .unsat_o     (unsat),
        .ack_v_o     (ack_out_o),
        .ack_dst_o   (ack_dst_o)
    );
endmodule

// Property checker for the rollback sequencer.
// Assumes: bound to chunk_rollback_seq; live count stable during recovery.
module chunk_rollback_seq_chk #(
    parameter int NCHUNK = 4,
    parameter int NCORE  = 4,
    parameter int CW     = $clog2(NCHUNK)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fault_i,
    input logic [CW:0]      live_cnt_i,
    input logic [NCORE-1:0] rb_out_o,
    input logic             undo_req_o,
    input logic [CW-1:0]    undo_chunk_o,
    input logic             undo_done_i,
    input logic             ckpt_restore_o,
    input logic             stall_o,
    input logic [NCORE-1:0] pend_mask
);
    logic          have_q;
    logic [CW-1:0] prev_q;

    // Remember the last chunk whose undo completed in this walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_q <= 1'b0;
            prev_q <= '0;
        end else if (ckpt_restore_o) begin
            have_q <= 1'b0;
        end else if (undo_req_o && undo_done_i) begin
            have_q <= 1'b1;
            prev_q <= undo_chunk_o;
        end
    end

    // R2
    fault_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_i && !stall_o) |=> stall_o);

    // R3
    first_youngest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(undo_req_o) && !have_q) |-> (undo_chunk_o == CW'(live_cnt_i - 1'b1)));

    // R3
    next_older_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(undo_req_o) && have_q) |-> (undo_chunk_o == CW'(prev_q - 1'b1)));

    // R5
    no_undo_with_acks_owed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        undo_req_o |-> (pend_mask == '0));

    // R5
    rb_strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_out_o != '0) |=> (rb_out_o == '0));

    // R8
    ckpt_then_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ckpt_restore_o |=> (!ckpt_restore_o && !stall_o));

    // R2
    activity_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (undo_req_o || ckpt_restore_o || (rb_out_o != '0)) |-> stall_o);
endmodule

bind chunk_rollback_seq chunk_rollback_seq_chk #(
    .NCHUNK(NCHUNK), .NCORE(NCORE), .CW(CW)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .fault_i        (fault_i),
    .live_cnt_i     (live_cnt_i),
    .rb_out_o       (rb_out_o),
    .undo_req_o     (undo_req_o),
    .undo_chunk_o   (undo_chunk_o),
    .undo_done_i    (undo_done_i),
    .ckpt_restore_o (ckpt_restore_o),
    .stall_o        (stall_o),
    .pend_mask      (pend_mask)
);

// File: tb/chunk_rollback_seq_tb.sv
// Scoreboard bench: tasks queue the expected event stream, a monitor
// compares every observed event against the head of the queue.
module chunk_rollback_seq_tb;
    localparam int NCHUNK = 4;
    localparam int NCORE  = 4;
    localparam int CW     = 2;
    localparam int NW     = 2;

    // Event kinds, compared in this order within one cycle.
    localparam int EV_RISE = 5, EV_FALL = 6, EV_ACK = 3, EV_RB = 2, EV_UNDO = 1, EV_CKPT = 4;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    fault_i = 1'b0;
    logic [CW:0]             live_cnt_i = '0;
    logic [NCHUNK*NCORE-1:0] prod_map_i = '0;
    logic                    rb_req_i = 1'b0;
    logic [NW-1:0]           rb_src_i = '0;
    logic [CW-1:0]           rb_chunk_i = '0;
    logic [NCORE-1:0]        ack_in_i = '0;
    logic                    undo_done_i = 1'b0;
    logic [NCORE-1:0]        rb_out_o;
    logic                    ack_out_o;
    logic [NW-1:0]           ack_dst_o;
    logic                    undo_req_o;
    logic [CW-1:0]           undo_chunk_o;
    logic                    ckpt_restore_o;
    logic                    stall_o;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    exp_q[$];
    string tag_q[$];
    int    early_undo = 0;
    bit    done_flag = 1'b0;

    chunk_rollback_seq #(.NCHUNK(NCHUNK), .NCORE(NCORE)) u_dut (.*);

    always #10 clk = ~clk;

    // Queue one expected event.
    task automatic expect_ev(input int kind, input int val, input string tag);
        exp_q.push_back(kind * 256 + val);
        tag_q.push_back(tag);
    endtask

    // Compare one observed event with the queue head.
    task automatic seen(input int kind, input int val);
        int got;
        got = kind * 256 + val;
        n_cmp++;
        if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL unexpected event: got %0h expected none", got);
        end else begin
            int    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (e != got) begin
                n_bad++;
                $display("FAIL %s: got %0h expected %0h", t, got, e);
            end
        end
    endtask

    // Monitor: turns port activity into events, away from the clock edge.
    logic pstall = 1'b0, pundo = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (stall_o && !pstall) seen(EV_RISE, 0);
            if (!stall_o && pstall) seen(EV_FALL, 0);
            if (ack_out_o) seen(EV_ACK, int'(ack_dst_o));
            if (rb_out_o != '0) seen(EV_RB, int'(rb_out_o));
            if (undo_req_o && !pundo) seen(EV_UNDO, int'(undo_chunk_o));
            if (ckpt_restore_o) seen(EV_CKPT, 0);
        end
        pstall = stall_o;
        pundo  = undo_req_o;
    end

    // Log-walking unit model: finishes each undo in one cycle.
    always @(negedge clk) undo_done_i <= undo_req_o && !undo_done_i;

    // Consumer cores model: stray acks from unlisted cores, then real ones.
    logic [NCORE-1:0] owe = '0;
    int               cd = 0;
    always @(negedge clk) begin
        ack_in_i <= '0;
        if (undo_req_o && owe != '0) early_undo++;
        if (rb_out_o != '0) begin
            owe <= rb_out_o;
            cd  <= 6;
        end else if (owe != '0) begin
            if (cd > 0) begin
                cd <= cd - 1;
                if (cd == 3) ack_in_i <= ~owe;
            end else begin
                ack_in_i <= owe & (~owe + 1'b1);
                owe      <= owe & (owe - 1'b1);
            end
        end
    end

    task automatic send_req(input int src, input int chunk);
        @(negedge clk);
        rb_req_i   = 1'b1;
        rb_src_i   = NW'(src);
        rb_chunk_i = CW'(chunk);
        @(negedge clk);
        rb_req_i = 1'b0;
    endtask

    task automatic pulse_fault();
        @(negedge clk);
        fault_i = 1'b1;
        @(negedge clk);
        fault_i = 1'b0;
    endtask

    // Let the run settle, then require every expected event to have occurred.
    task automatic settle(input string tag);
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (exp_q.size() == 0 && !stall_o) break;
        end
        repeat (6) @(negedge clk);
        n_cmp++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL %s: %0d events missing, expected 0", tag, exp_q.size());
            exp_q.delete();
            tag_q.delete();
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        n_cmp++;
        if (stall_o || undo_req_o || ckpt_restore_o || ack_out_o || rb_out_o != '0) begin
            n_bad++;
            $display("FAIL R1: outputs %b%b%b%b %h expected all zero",
                     stall_o, undo_req_o, ckpt_restore_o, ack_out_o, rb_out_o);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 R3 R4 R5 R7 R8: fault, rows on chunks 2 and 0, late request for chunk 3
        live_cnt_i = 3'd4;
        prod_map_i = 16'h040A;
        expect_ev(EV_RISE, 0, "R2 stall rise");
        expect_ev(EV_UNDO, 3, "R3 youngest first");
        expect_ev(EV_RB, 4, "R5 rollback row chunk2");
        expect_ev(EV_UNDO, 2, "R5 undo after acks");
        expect_ev(EV_UNDO, 1, "R4 empty row undo");
        expect_ev(EV_RB, 10, "R5 rollback row chunk0");
        expect_ev(EV_ACK, 0, "R7 already undone ack");
        expect_ev(EV_UNDO, 0, "R3 oldest last");
        expect_ev(EV_CKPT, 0, "R8 checkpoint");
        expect_ev(EV_FALL, 0, "R8 stall release");
        pulse_fault();
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (rb_out_o == 4'b1010) break;
        end
        send_req(0, 3);
        settle("R5 fault walk");

        // R6 R9: external request starts the walk, second request queued
        prod_map_i = '0;
        expect_ev(EV_RISE, 0, "R6 request starts walk");
        expect_ev(EV_UNDO, 3, "R3 chunk3");
        expect_ev(EV_UNDO, 2, "R3 chunk2");
        expect_ev(EV_ACK, 1, "R6 ack after target undone");
        expect_ev(EV_UNDO, 1, "R3 chunk1");
        expect_ev(EV_UNDO, 0, "R3 chunk0");
        expect_ev(EV_CKPT, 0, "R8 checkpoint");
        expect_ev(EV_FALL, 0, "R8 stall release");
        expect_ev(EV_ACK, 3, "R9 queued request acked");
        send_req(1, 2);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (undo_req_o) break;
        end
        send_req(3, 0);
        settle("R9 external walk");

        // R7: idle request for a chunk not in flight
        live_cnt_i = 3'd2;
        expect_ev(EV_ACK, 2, "R7 not in flight ack");
        send_req(2, 3);
        settle("R7 idle ack");

        // R6: idle request for the younger of two live chunks
        expect_ev(EV_RISE, 0, "R6 stall rise");
        expect_ev(EV_UNDO, 1, "R3 chunk1 of two");
        expect_ev(EV_ACK, 1, "R6 ack target1");
        expect_ev(EV_UNDO, 0, "R3 chunk0 of two");
        expect_ev(EV_CKPT, 0, "R8 checkpoint");
        expect_ev(EV_FALL, 0, "R8 stall release");
        send_req(1, 1);
        settle("R6 two-chunk walk");

        // R10: no live chunks
        live_cnt_i = '0;
        expect_ev(EV_RISE, 0, "R10 stall rise");
        expect_ev(EV_CKPT, 0, "R10 checkpoint without undo");
        expect_ev(EV_FALL, 0, "R10 stall release");
        pulse_fault();
        settle("R10 empty walk");

        // R5: no undo while consumer acks were outstanding
        n_cmp++;
        if (early_undo != 0) begin
            n_bad++;
            $display("FAIL R5: %0d undo cycles with acks owed, expected 0", early_undo);
        end

        done_flag = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule